// File: doc/BRIEF.md
# Fetch-Stage Two-Bit Direction Predictor with Tagged Target Buffer

This block sits beside the instruction fetch and guesses where the next fetch goes. The fetch address selects one entry in a table of two-bit saturating counters and, in parallel, one entry in a direct-mapped target buffer. No decode of the instruction is needed. Both reads are combinational, so the direction guess, the buffer hit flag and the next fetch address are all ready in the same cycle as the fetch address. If the buffer entry matches and the counter says taken, the stored target becomes the next address. In every other case fetch continues with the address plus four.

When a branch resolves later in the pipeline, its word address, actual direction and target arrive on the training port. The counter for that branch moves one step toward the actual direction. A taken branch also writes its tag and target into the buffer. A write lands at the clock edge, so a lookup in the same cycle still sees the older contents.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset every counter holds weak not-taken (01) and every buffer entry is invalid, so any fetch address gives pred_taken=0, btb_hit=0 and next_pc=fetch_pc+4.
- R2: The entry is chosen by fetch_pc[IDX_W+1:2] (default bits 7:2). The buffer tag is fetch_pc[PC_W-1:IDX_W+2]. fetch_pc[1:0] affects neither the index nor the tag.
- R3: Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. pred_taken is the counter MSB. A taken training step adds one and saturates at 11.
- R4: A counter at strong taken keeps predicting taken after one not-taken training step. It predicts not-taken only after a second one.
- R5: A not-taken training step subtracts one and saturates at 00. From 00, two taken steps are needed before the prediction is taken.
- R6: A taken training step writes the tag upd_pc[PC_W-1:IDX_W+2], the target and a valid bit into the buffer entry at its index. A later lookup with a matching tag raises btb_hit.
- R7: A not-taken training step leaves the buffer entry unchanged.
- R8: A fetch address that shares an index with a stored branch but has a different tag gives btb_hit=0 and next_pc=fetch_pc+4. pred_taken still reflects the shared counter.
- R9: next_pc equals the stored target only when btb_hit=1 and pred_taken=1. Otherwise it equals fetch_pc+4, and that includes a hit with a not-taken prediction.
- R10: When training and lookup address the same entry in one cycle, the lookup returns the contents from before the training step. The new contents are seen from the next cycle.
- R11: A taken training step on an index that holds a different tag replaces that entry. The old branch then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_taken | output | 1 | Direction guess (counter MSB) |
| btb_hit | output | 1 | Buffer entry valid and tag matches |
| next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W-2 | Word address of the resolved branch (bits PC_W-1:2) |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |

## Verification
All three lookup results depend combinationally on fetch_pc and on stored state, so they are due in the same cycle as the fetch address. The bench drives each cycle's inputs just after the rising edge and compares the outputs at the falling edge of that same cycle. A training step changes state only at the following rising edge, so its effect is due from the next cycle's lookup. The bench's reference model applies each training step only after it has computed the expected lookup for that cycle. This gives the pre-update view when training and lookup share an entry.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam logic [1:0] CTR_RESET = CTR_WNT;

  // one saturating training step
  function automatic logic [1:0] ctr_train(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == CTR_ST)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_dir(input logic [1:0] cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import bp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] ctr_q [DEPTH];
  logic [1:0] wr_old_w;
  logic [1:0] wr_new_w;

  assign wr_old_w = ctr_q[wr_idx];
  assign wr_new_w = ctr_train(wr_old_w, wr_taken);
  assign rd_ctr   = ctr_q[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ctr_q[g] <= CTR_RESET;
      else if (wr_en && wr_idx == IDX_W'(g)) ctr_q[g] <= wr_new_w;
    end
  end

  // R3: a taken step moves up by one or stays saturated at 11
  a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken |=>
      (ctr_q[$past(wr_idx)] == $past(wr_old_w) + 2'd1) ||
      ($past(wr_old_w) == 2'b11 && ctr_q[$past(wr_idx)] == 2'b11));

  // R5: a not-taken step moves down by one or stays saturated at 00
  a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken |=>
      (ctr_q[$past(wr_idx)] == $past(wr_old_w) - 2'd1) ||
      ($past(wr_old_w) == 2'b00 && ctr_q[$past(wr_idx)] == 2'b00));

endmodule

// File: rtl/bp_tgt_buf.sv
module bp_tgt_buf #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_valid,
  input  logic             wr_taken,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target
);
  localparam int DEPTH = 1 << IDX_W;

  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic             alloc_w;

  assign alloc_w   = wr_valid && wr_taken;
  assign rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_target = tgt_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
    end else if (alloc_w) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_w) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_target;
    end
  end

  // R6: a taken step leaves a valid entry holding its tag and target
  a_r6_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_taken |=>
      vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag) &&
      tgt_q[$past(wr_idx)] == $past(wr_target));

  // R7: a not-taken step leaves the entry as it was
  a_r7_nt_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_taken |=>
      vld_q[$past(wr_idx)] == $past(vld_q[wr_idx]) &&
      tag_q[$past(wr_idx)] == $past(tag_q[wr_idx]) &&
      tgt_q[$past(wr_idx)] == $past(tgt_q[wr_idx]));

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic            btb_hit,
  output logic [PC_W-1:0] next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:2] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  import bp_pkg::*;

  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int TAG_LO = IDX_W + 2;

  function automatic logic [PC_W-1:0] pick_next(input logic hit, input logic taken,
                                                input logic [PC_W-1:0] seq,
                                                input logic [PC_W-1:0] tgt);
    return (hit && taken) ? tgt : seq;
  endfunction

  logic [IDX_W-1:0] fetch_idx_w;
  logic [TAG_W-1:0] fetch_tag_w;
  logic [IDX_W-1:0] upd_idx_w;
  logic [TAG_W-1:0] upd_tag_w;
  logic [1:0]       fetch_ctr_w;
  logic             taken_w;
  logic             hit_w;
  logic [PC_W-1:0]  tgt_w;
  logic [PC_W-1:0]  seq_pc_w;

  assign fetch_idx_w = fetch_pc[TAG_LO-1:2];
  assign fetch_tag_w = fetch_pc[PC_W-1:TAG_LO];
  assign upd_idx_w   = upd_pc[TAG_LO-1:2];
  assign upd_tag_w   = upd_pc[PC_W-1:TAG_LO];
  assign seq_pc_w    = fetch_pc + PC_W'(4);

  bp_ctr_table #(.IDX_W(IDX_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (fetch_idx_w),
    .rd_ctr   (fetch_ctr_w),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx_w),
    .wr_taken (upd_taken)
  );

  bp_tgt_buf #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_btb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (fetch_idx_w),
    .rd_tag    (fetch_tag_w),
    .rd_hit    (hit_w),
    .rd_target (tgt_w),
    .wr_valid  (upd_valid),
    .wr_taken  (upd_taken),
    .wr_idx    (upd_idx_w),
    .wr_tag    (upd_tag_w),
    .wr_target (upd_target)
  );

  assign taken_w    = ctr_dir(fetch_ctr_w);
  assign pred_taken = taken_w;
  assign btb_hit    = hit_w;
  assign next_pc    = pick_next(hit_w, taken_w, seq_pc_w, tgt_w);

  // R9: without a taken hit, fetch goes on sequentially
  a_r9_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    !(btb_hit && pred_taken) |-> next_pc == fetch_pc + PC_W'(4));

  // R9: a taken hit redirects to the stored target
  a_r9_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    btb_hit && pred_taken |-> next_pc == tgt_w);

endmodule

// File: tb/bp_fetch_predictor_tb.sv
`timescale 1ns/1ps
module bp_fetch_predictor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = 32'h0;
  logic        pred_taken, btb_hit;
  logic [31:0] next_pc;
  logic        upd_valid = 1'b0;
  logic [31:2] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = 32'h0;

  always #4 clk = ~clk;

  bp_fetch_predictor #(.PC_W(32), .IDX_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .btb_hit(btb_hit), .next_pc(next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  typedef struct {
    logic        t;
    logic        h;
    logic [31:0] np;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model, kept in its own form
  int          m_cnt [64];
  bit          m_vld [64];
  logic [23:0] m_tag [64];
  logic [31:0] m_tgt [64];

  function automatic int slot(input logic [31:0] a);
    return int'((a / 4) % 64);
  endfunction

  task automatic step(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                      input logic ut, input logic [31:0] utgt, input string req);
    exp_t e;
    int s;
    @(posedge clk); #1;
    fetch_pc = pc; upd_valid = uv; upd_pc = upc[31:2]; upd_taken = ut; upd_target = utgt;
    s = slot(pc);
    e.t = (m_cnt[s] >= 2);
    e.h = m_vld[s] && (m_tag[s] == pc[31:8]);
    e.np = (e.t && e.h) ? m_tgt[s] : pc + 32'd4;
    e.req = req;
    q.push_back(e);
    if (uv) begin
      s = slot(upc);
      if (ut) begin
        if (m_cnt[s] < 3) m_cnt[s]++;
        m_vld[s] = 1; m_tag[s] = upc[31:8]; m_tgt[s] = utgt;
      end else if (m_cnt[s] > 0) m_cnt[s]--;
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pred_taken !== e.t || btb_hit !== e.h || next_pc !== e.np) begin
        errors++;
        $display("FAIL %s pc=%h actual t=%b h=%b np=%h expected t=%b h=%b np=%h",
                 e.req, fetch_pc, pred_taken, btb_hit, next_pc, e.t, e.h, e.np);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_cnt[i] = 1; m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    fetch_pc = 32'h100;
    #20;
    checks++;  // R1 during reset
    if (pred_taken !== 1'b0 || btb_hit !== 1'b0 || next_pc !== 32'h104) begin
      errors++;
      $display("FAIL R1 reset actual t=%b h=%b np=%h expected t=0 h=0 np=00000104",
               pred_taken, btb_hit, next_pc);
    end
    @(posedge clk); #1; rst_n = 1'b1;

    step(32'h1000, 0, 0, 0, 0, "R1");
    step(32'h13C, 0, 0, 0, 0, "R1");
    // R10: train and look up the same entry in one cycle
    step(32'h1000, 1, 32'h1000, 1, 32'h2000, "R10");
    step(32'h1000, 0, 0, 0, 0, "R3_R6_R9");
    step(32'h1002, 0, 0, 0, 0, "R2");
    step(32'h1003, 1, 32'h1000, 1, 32'h2000, "R2");
    // R4: from strong taken, one not-taken keeps taken, the second flips it
    step(32'h1000, 1, 32'h1000, 0, 32'h5550, "R4");
    step(32'h1000, 1, 32'h1000, 0, 32'h5550, "R4_R7");
    step(32'h1000, 0, 0, 0, 0, "R4_R9");
    // R5: saturate low, then two taken steps are needed
    step(32'h1000, 1, 32'h1000, 0, 0, "R5");
    step(32'h1000, 1, 32'h1000, 0, 0, "R5");
    step(32'h1000, 1, 32'h1000, 1, 32'h2000, "R5");
    step(32'h1000, 1, 32'h1000, 1, 32'h2000, "R5");
    step(32'h1000, 0, 0, 0, 0, "R5");
    // R8: alias with the same index but a different tag
    step(32'h1100, 0, 0, 0, 0, "R8");
    // R11: replace the entry with another branch
    step(32'h1100, 1, 32'h1100, 1, 32'h3000, "R11");
    step(32'h1100, 0, 0, 0, 0, "R11");
    step(32'h1000, 0, 0, 0, 0, "R11");
    // R7: a not-taken step on a fresh entry allocates nothing
    step(32'h2040, 1, 32'h2040, 0, 32'h7000, "R7");
    step(32'h2040, 0, 0, 0, 0, "R7");
    // R6: fill several indices, then read them back
    for (int i = 0; i < 8; i++)
      step(32'h4010 + 4*i, 1, 32'h4010 + 4*i, 1, 32'h8000 + 16*i, "R6");
    for (int i = 0; i < 8; i++)
      step(32'h4010 + 4*i, 0, 0, 0, 0, "R6_R3");
    step(32'h4010, 1, 32'h4010, 0, 0, "R10");
    step(32'h4010, 0, 0, 0, 0, "R5");

    @(posedge clk); #1; upd_valid = 1'b0;
    @(negedge clk); #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule